// File: doc/BRIEF.md
# Stop Mode Recovery Delay Counter

This block times how long a device waits after leaving a low-power stop state before its processor clock is allowed to run again. A free-running counter advances on every oscillator clock cycle. A stop request clears the counter and parks it at zero. A wake event then starts a recovery wait. The event may come from the interrupt or break logic, or from the external reset pin while stopped. The wait is either long or short, and the choice is made at run time by a select input that is sampled only at the moment of waking.

When the selected number of cycles has elapsed, the block emits a single-cycle completion pulse that releases the processor clock, and the counter then keeps running freely. The external reset pin never changes the counter value. It only acts as a wake source while the block is stopped. A stop request always wins: it aborts a wait in progress, and it overrides a wake or an expiry that falls in the same cycle.

Top module: `stop_wake_timer`

## Requirements
- R1: In the clock edge where `stop_req` is high, the counter clears to 0. While the block is stopped and no wake source is high, `cnt_out` stays at 0.
- R2: While stopped, a high `wake_evt` or a high `ext_rst` at a clock edge starts the recovery wait. The counter is still 0 after that edge.
- R3: `short_sel` is captured only at the wake edge (1 = short, 0 = long). Changing it during the wait does not alter the delay.
- R4: With the long delay captured, `wake_done` is high exactly 4096 clock edges after the wake edge, and `cnt_out` reads 4096 in that cycle.
- R5: With the short delay captured, `wake_done` is high exactly 32 clock edges after the wake edge, and `cnt_out` reads 32 in that cycle.
- R6: Outside the stopped state, `ext_rst` has no effect: the counter keeps advancing by one per clock edge.
- R7: After power-on reset (`rst_n` low, sampled synchronously), `cnt_out` is 0 and `wake_done` is 0. After reset and after each completed recovery, the counter advances by one per edge and wraps modulo 2^CNT_W.
- R8: `wake_done` is never high for two consecutive cycles.
- R9: A wake source raised during the recovery wait, or while running freely, is ignored. The wait is not restarted and its completion cycle is unchanged.
- R10: A stop request during the recovery wait aborts it. The counter clears to 0, no `wake_done` follows, and the block remains stopped until a new wake.
- R11: A stop request takes priority over a wake in the same cycle, and over the expiry of the wait in the same cycle. In both cases the counter is 0 afterwards and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst | input | 1 | External reset pin level, active high; wake source while stopped only |
| stop_req | input | 1 | Stop command; clears the counter and enters the stopped state |
| wake_evt | input | 1 | Interrupt or break wake request |
| short_sel | input | 1 | Delay select sampled at wake: 1 short, 0 long |
| cnt_out | output | CNT_W | Current counter value |
| wake_done | output | 1 | One-cycle pulse when the recovery delay expires |

## Verification
Two functions can fall into the same clock edge: an abort by a stop request, and the expiry of the recovery wait (or, in the stopped state, the start of a wait). The bench counts edges after a short-delay wake until `cnt_out` reads 31. It then raises `stop_req` for exactly the edge that would have produced the pulse, and also raises it together with `wake_evt` while stopped. Each case passes only if `cnt_out` is 0 afterwards and `wake_done` stays low for the following tens of cycles. The random phase then mixes sparse stops, wakes and reset-pin pulses, and compares both outputs against a bench model on every cycle.

// File: rtl/swt_pkg.sv
// Package: shared types for the stop/wake recovery timer.
// Assumes: nothing beyond a single clock domain.
package swt_pkg;

    // Operating states of the timer.
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,   // counter free-running
        ST_STOP = 2'd1,   // stopped, counter parked at zero
        ST_WAIT = 2'd2    // recovery wait in progress
    } swt_state_e;

endpackage

// File: rtl/swt_delay_sel.sv
// Module: swt_delay_sel
// Captures the short/long choice at the wake edge and presents the terminal
// count (delay minus one) that the wait compares against.
// Assumes: LONG_DLY and SHORT_DLY are at least 1 and below 2**CNT_W.
module swt_delay_sel #(
    parameter int CNT_W     = 13,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             short_sel,
    output logic             sel_q,
    output logic [CNT_W-1:0] term
);
    localparam logic [CNT_W-1:0] LONG_TERM  = CNT_W'(LONG_DLY - 1);
    localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'(SHORT_DLY - 1);

    // Latch the delay choice only when a wait starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (load) begin
            sel_q <= short_sel;
        end
    end

    // Select the terminal count for the captured choice.
    always_comb begin
        term = sel_q ? SHORT_TERM : LONG_TERM;
    end
endmodule

// File: rtl/swt_counter.sv
// Module: swt_counter
// Counter that clears on request, holds when told, and otherwise increments
// with natural wrap.
// Assumes: clr has priority over hold.
module swt_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance, hold or clear the count each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/swt_ctrl.sv
// Module: swt_ctrl
// State machine for stop, wait and free-run, plus the registered done pulse.
// Assumes: hit is high when the counter equals the captured terminal count;
// stop_req overrides every other input.
module swt_ctrl
    import swt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wake,
    input  logic       hit,
    output swt_state_e state,
    output logic       load,
    output logic       done
);
    swt_state_e nxt;
    logic       fin;

    // Decide the next state and the one-cycle actions.
    always_comb begin
        nxt  = state;
        load = 1'b0;
        fin  = 1'b0;
        if (stop_req) begin
            nxt = ST_STOP;
        end else begin
            case (state)
                ST_STOP: begin
                    if (wake) begin
                        nxt  = ST_WAIT;
                        load = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (hit) begin
                        nxt = ST_RUN;
                        fin = 1'b1;
                    end
                end
                default: nxt = state;
            endcase
        end
    end

    // Register the state and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= fin;
        end
    end
endmodule

// File: rtl/stop_wake_timer.sv
// Module: stop_wake_timer (top)
// Free-running counter reused as the wake-up delay timer after a stop state.
// Assumes: all inputs synchronous to clk; ext_rst is the already-synchronised
// external reset pin level and never resets this block.
module stop_wake_timer
    import swt_pkg::*;
#(
    parameter int CNT_W     = 13,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst,
    input  logic             stop_req,
    input  logic             wake_evt,
    input  logic             short_sel,
    output logic [CNT_W-1:0] cnt_out,
    output logic             wake_done
);
    swt_state_e       state;
    logic             load;
    logic             sel_q;
    logic [CNT_W-1:0] term;
    logic             hit;
    logic             wake;

    // Combine the wake sources and compare against the terminal count.
    always_comb begin
        wake = wake_evt | ext_rst;
        hit  = (cnt_out == term);
    end

    swt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .wake     (wake),
        .hit      (hit),
        .state    (state),
        .load     (load),
        .done     (wake_done)
    );

    swt_delay_sel #(
        .CNT_W     (CNT_W),
        .LONG_DLY  (LONG_DLY),
        .SHORT_DLY (SHORT_DLY)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .short_sel (short_sel),
        .sel_q     (sel_q),
        .term      (term)
    );

    swt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stop_req),
        .hold  (state == ST_STOP),
        .cnt   (cnt_out)
    );
endmodule

// File: rtl/swt_checker.sv
// Module: swt_checker
// Concurrent properties for stop_wake_timer, attached by bind.
// Assumes: parameters match the bound instance.
module swt_checker #(
    parameter int CNT_W     = 13,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic [CNT_W-1:0] cnt_out,
    input logic             wake_done,
    input logic             sel_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (cnt_out == '0)); // R1
    AST_DONE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && !sel_q) |-> (cnt_out == CNT_W'(LONG_DLY))); // R4
    AST_DONE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && sel_q) |-> (cnt_out == CNT_W'(SHORT_DLY))); // R5
    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req && cnt_out != '0) |=> (cnt_out == $past(cnt_out) + ONE)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done); // R8
    AST_STOP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !wake_done); // R11
endmodule

bind stop_wake_timer swt_checker #(
    .CNT_W     (CNT_W),
    .LONG_DLY  (LONG_DLY),
    .SHORT_DLY (SHORT_DLY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .cnt_out   (cnt_out),
    .wake_done (wake_done),
    .sel_q     (sel_q)
);

// File: tb/sim_stop_wake_timer.sv
// Bench for stop_wake_timer: directed corner cases plus seeded random
// stimulus compared against a bench-side model every cycle.
module sim_stop_wake_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 13;
    localparam int LONG_DLY   = 4096;
    localparam int SHORT_DLY  = 32;
    localparam int WD_LIMIT   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_rst = 1'b0;
    logic             stop_req = 1'b0;
    logic             wake_evt = 1'b0;
    logic             short_sel = 1'b0;
    logic [CNT_W-1:0] cnt_out;
    logic             wake_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Bench model state: 0 run, 1 stopped, 2 waiting.
    int          m_state = 0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic        m_sel = 1'b0;
    logic        m_done = 1'b0;

    stop_wake_timer #(
        .CNT_W(CNT_W), .LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .stop_req(stop_req),
        .wake_evt(wake_evt), .short_sel(short_sel),
        .cnt_out(cnt_out), .wake_done(wake_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int delay_of(input logic sel);
        return sel ? SHORT_DLY : LONG_DLY;
    endfunction

    // Advance the model by one edge from the requirements.
    task automatic model_edge();
        if (!rst_n) begin
            m_state = 0; m_cnt = '0; m_sel = 1'b0; m_done = 1'b0;
        end else if (stop_req) begin
            m_state = 1; m_cnt = '0; m_done = 1'b0;
        end else if (m_state == 1) begin
            m_done = 1'b0;
            if (wake_evt || ext_rst) begin
                m_state = 2; m_sel = short_sel;
            end
        end else if (m_state == 2) begin
            m_done = (int'(m_cnt) == delay_of(m_sel) - 1);
            if (m_done) m_state = 0;
            m_cnt = m_cnt + 1'b1;
        end else begin
            m_done = 1'b0;
            m_cnt = m_cnt + 1'b1;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        cycles++;
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Step until wake_done rises; returns the number of edges taken.
    task automatic edges_to_done(input int limit, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!wake_done && n < limit);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            if (cycles > WD_LIMIT) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WD_LIMIT);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        int n;
        logic [CNT_W-1:0] c0;
        void'($urandom(32'd7341));

        repeat (3) step();
        check("R7 reset count", int'(cnt_out), 0);
        check("R7 reset done", int'(wake_done), 0);
        rst_n = 1'b1;
        repeat (5) step();
        check("R7 free run after reset", int'(cnt_out), 5);

        // R6: reset pin while running leaves the count advancing.
        c0 = cnt_out;
        ext_rst = 1'b1;
        repeat (4) step();
        ext_rst = 1'b0;
        check("R6 ext_rst ignored", int'(cnt_out), int'(c0) + 4);

        // R1: stop clears and holds.
        stop_req = 1'b1; step(); stop_req = 1'b0;
        check("R1 stop clears", int'(cnt_out), 0);
        repeat (10) step();
        check("R1 hold while stopped", int'(cnt_out), 0);

        // R5/R3/R8: short wake, select flipped during the wait.
        short_sel = 1'b1; wake_evt = 1'b1; step(); wake_evt = 1'b0;
        check("R2 count after wake", int'(cnt_out), 0);
        short_sel = 1'b0;
        edges_to_done(5000, n);
        check("R5 R3 short delay edges", n, SHORT_DLY);
        check("R5 count at done", int'(cnt_out), SHORT_DLY);
        step();
        check("R8 pulse one cycle", int'(wake_done), 0);
        check("R7 runs after recovery", int'(cnt_out), SHORT_DLY + 1);

        // R4/R2/R9: long wake via reset pin, extra wake mid-wait.
        stop_req = 1'b1; step(); stop_req = 1'b0;
        ext_rst = 1'b1; short_sel = 1'b0; step(); ext_rst = 1'b0;
        repeat (99) step();
        wake_evt = 1'b1; short_sel = 1'b1; step(); wake_evt = 1'b0;
        edges_to_done(5000, n);
        check("R4 R2 R9 long delay edges", n + 100, LONG_DLY);
        check("R4 count at done", int'(cnt_out), LONG_DLY);
        step();
        check("R8 pulse one cycle long", int'(wake_done), 0);

        // R10: stop aborts a wait.
        stop_req = 1'b1; step(); stop_req = 1'b0;
        short_sel = 1'b1; wake_evt = 1'b1; step(); wake_evt = 1'b0;
        repeat (10) step();
        stop_req = 1'b1; step(); stop_req = 1'b0;
        check("R10 abort clears", int'(cnt_out), 0);
        n = 0;
        repeat (40) begin step(); n += int'(wake_done); end
        check("R10 no pulse after abort", n, 0);
        check("R10 stays stopped", int'(cnt_out), 0);

        // R11: stop together with wake.
        stop_req = 1'b1; wake_evt = 1'b1; step(); stop_req = 1'b0; wake_evt = 1'b0;
        n = 0;
        repeat (50) begin step(); n += int'(wake_done); end
        check("R11 stop beats wake pulse", n, 0);
        check("R11 stop beats wake count", int'(cnt_out), 0);

        // R11: stop in the expiry cycle.
        short_sel = 1'b1; wake_evt = 1'b1; step(); wake_evt = 1'b0;
        repeat (SHORT_DLY - 1) step();
        check("R11 setup count", int'(cnt_out), SHORT_DLY - 1);
        stop_req = 1'b1; step(); stop_req = 1'b0;
        check("R11 stop beats expiry done", int'(wake_done), 0);
        check("R11 stop beats expiry count", int'(cnt_out), 0);
        n = 0;
        repeat (40) begin step(); n += int'(wake_done); end
        check("R11 no late pulse", n, 0);

        // Random phase against the model.
        for (int i = 0; i < 20000; i++) begin
            stop_req  = ($urandom_range(0, 999) < 2);
            wake_evt  = ($urandom_range(0, 99) < 3);
            ext_rst   = ($urandom_range(0, 99) < 2);
            short_sel = ($urandom_range(0, 3) != 0);
            step();
            check("R1 R7 R9 random count", int'(cnt_out), int'(m_cnt));
            check("R4 R5 R8 random done", int'(wake_done), int'(m_done));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule